// File: doc/BRIEF.md
# Time-Sliced Address Gate with Per-Window Word Budget

This block sits on one address channel of an AXI link and imitates competing traffic by choking that channel on a schedule. A free-running window counter alternates between an open phase, when address handshakes may complete, and a shut phase, when they may not. Both phase lengths are programmable cycle counts. The data channels of the link are not touched.

On top of the schedule, each open window carries a budget of 64-bit data words. The budget is refilled when an open window begins. A burst request passes only if its beat count, taken as the length field plus one, still fits in what is left of the budget. A burst that does not fit is held back until a later window. A word cap of zero removes the budget limit.

When the enable input is low, the gate is fully transparent and the schedule is held at its starting point. Rewriting either phase length restarts the schedule at the beginning of an open window.

Top module: `burst_window_gate`

## Requirements
- R1: With `enable` low, `slvValid` equals `mstValid` and `mstReady` equals `slvReady` in every cycle.
- R2: Suppose `enable` is high and both lengths are non-zero, and the schedule restarts at clock edge E. In the cycles that follow E, the gate is open for `onLen` cycles and then shut for `offLen` cycles, and this pattern repeats.
- R3: With `offLen` equal to 0, the window never shuts.
- R4: With `onLen` equal to 0 and `offLen` non-zero, the window never opens.
- R5: While the gate is shut, `mstReady` and `slvValid` are both 0, whatever `mstValid` and `slvReady` are.
- R6: A request whose `mstLen`+1 beats exceed the remaining budget is held: `slvValid` and `mstReady` are both 0. A request that fits passes, and its beat count is taken from the budget at the handshake edge.
- R7: With `wordCap` equal to 0, every request in an open window passes, whatever its length.
- R8: The budget is set to `wordCap` at every clock edge that starts an open window, and also at every restart.
- R9: Suppose `onLen` or `offLen` differs from its value in the previous cycle. The next clock edge then restarts the schedule at the first cycle of an open window.
- R10: While the gate is passing, `slvValid` follows `mstValid` and `mstReady` follows `slvReady`. As a result, a handshake completes on the master side exactly when it completes on the slave side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| enable | input | 1 | 1 applies the schedule; 0 makes the gate transparent |
| onLen | input | 16 | Open window length in cycles |
| offLen | input | 16 | Shut window length in cycles |
| wordCap | input | 16 | Words allowed per open window; 0 means no limit |
| mstValid | input | 1 | Address valid from the master |
| mstLen | input | 8 | Burst length field of the request (beats minus one) |
| slvReady | input | 1 | Address ready from the slave |
| mstReady | output | 1 | Gated address ready toward the master |
| slvValid | output | 1 | Gated address valid toward the slave |

## Verification
The assertions assume that the master holds its request stable while it waits. They also assume that `mstLen`+1 never exceeds a non-zero `wordCap`, since such a burst could never pass. They further assume that the phase lengths and the cap change only between scenarios, not as a stream of random values. The stimulus applies every configuration change at a single cycle, well away from the clock edge. It keeps each request's length within the cap whenever a cap is set, and it holds `mstValid` high across each waiting period, so that blocked and admitted requests can both be told apart at the ports.

// File: rtl/bwg_pkg.sv
package bwg_pkg;

  typedef enum logic {
    PH_OPEN = 1'b0,
    PH_SHUT = 1'b1
  } phase_e;

  // strobes issued by the control to the datapath registers
  typedef struct packed {
    logic cntClr;   // window counter back to zero
    logic cntInc;   // window counter advances
    logic budLoad;  // budget refilled from the cap
    logic budSub;   // accepted burst taken from the budget
  } gateStrobes_t;

endpackage

// File: rtl/bwg_datapath.sv
module bwg_datapath #(
  parameter int CNT_W = 16,
  parameter int CAP_W = 16,
  parameter int LEN_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bwg_pkg::gateStrobes_t strobes,
  input  logic [CNT_W-1:0]      onLen,
  input  logic [CNT_W-1:0]      offLen,
  input  logic [CAP_W-1:0]      wordCap,
  input  logic [LEN_W-1:0]      mstLen,
  output logic                  lenChg,
  output logic                  onZero,
  output logic                  offZero,
  output logic                  onDone,
  output logic                  offDone,
  output logic                  fits
);

  localparam int BEAT_W = CAP_W + 1;

  logic [CNT_W-1:0] winCnt;
  logic [CNT_W-1:0] onLenQ;
  logic [CNT_W-1:0] offLenQ;
  logic [CAP_W-1:0] budget;
  logic [BEAT_W-1:0] beats;
  logic             capZero;

  assign beats   = BEAT_W'(mstLen) + BEAT_W'(1);
  assign capZero = (wordCap == '0);
  assign onZero  = (onLen == '0);
  assign offZero = (offLen == '0);
  assign onDone  = (winCnt == onLen - CNT_W'(1));
  assign offDone = (winCnt == offLen - CNT_W'(1));
  assign lenChg  = (onLen != onLenQ) || (offLen != offLenQ);
  assign fits    = capZero || (beats <= {1'b0, budget});

  // shadow copies of the lengths, used to detect a rewrite
  always_ff @(posedge clk) begin
    onLenQ  <= onLen;
    offLenQ <= offLen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (strobes.cntClr) begin
      winCnt <= '0;
    end else if (strobes.cntInc) begin
      winCnt <= winCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      budget <= wordCap;
    end else if (strobes.budLoad) begin
      budget <= wordCap;
    end else if (strobes.budSub && !capZero) begin
      budget <= budget - beats[CAP_W-1:0];
    end
  end

endmodule

// File: rtl/bwg_ctrl.sv
module bwg_ctrl (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  logic                  lenChg,
  input  logic                  onZero,
  input  logic                  offZero,
  input  logic                  onDone,
  input  logic                  offDone,
  input  logic                  handshake,
  output bwg_pkg::gateStrobes_t strobes,
  output logic                  windowOpen
);

  import bwg_pkg::*;

  phase_e phase;
  phase_e phaseNext;
  logic   restart;

  assign restart    = !enable || lenChg;
  assign windowOpen = offZero || ((phase == PH_OPEN) && !onZero);

  always_comb begin
    phaseNext = phase;
    strobes   = '0;
    if (restart) begin
      phaseNext       = PH_OPEN;
      strobes.cntClr  = 1'b1;
      strobes.budLoad = 1'b1;
    end else if (phase == PH_OPEN) begin
      if (onZero || onDone) begin
        strobes.cntClr = 1'b1;
        if (offZero) begin
          strobes.budLoad = 1'b1;     // back-to-back open windows
        end else begin
          phaseNext = PH_SHUT;
        end
      end else begin
        strobes.cntInc = 1'b1;
      end
    end else begin
      if (offZero || offDone) begin
        phaseNext       = PH_OPEN;
        strobes.cntClr  = 1'b1;
        strobes.budLoad = 1'b1;
      end else begin
        strobes.cntInc = 1'b1;
      end
    end
    // a refill at this edge overrides the spend of the closing window
    strobes.budSub = handshake && !strobes.budLoad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_OPEN;
    end else begin
      phase <= phaseNext;
    end
  end

endmodule

// File: rtl/burst_window_gate.sv
module burst_window_gate #(
  parameter int CNT_W = 16,
  parameter int CAP_W = 16,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [CNT_W-1:0] onLen,
  input  logic [CNT_W-1:0] offLen,
  input  logic [CAP_W-1:0] wordCap,
  input  logic             mstValid,
  input  logic [LEN_W-1:0] mstLen,
  input  logic             slvReady,
  output logic             mstReady,
  output logic             slvValid
);

  bwg_pkg::gateStrobes_t strobes;
  logic lenChg, onZero, offZero, onDone, offDone, fits;
  logic windowOpen, pass, handshake;

  assign pass      = !enable || (windowOpen && fits);
  assign slvValid  = mstValid && pass;
  assign mstReady  = slvReady && pass;
  assign handshake = slvValid && slvReady;

  bwg_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .lenChg     (lenChg),
    .onZero     (onZero),
    .offZero    (offZero),
    .onDone     (onDone),
    .offDone    (offDone),
    .handshake  (handshake),
    .strobes    (strobes),
    .windowOpen (windowOpen)
  );

  bwg_datapath #(
    .CNT_W (CNT_W),
    .CAP_W (CAP_W),
    .LEN_W (LEN_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .onLen   (onLen),
    .offLen  (offLen),
    .wordCap (wordCap),
    .mstLen  (mstLen),
    .lenChg  (lenChg),
    .onZero  (onZero),
    .offZero (offZero),
    .onDone  (onDone),
    .offDone (offDone),
    .fits    (fits)
  );

endmodule

// File: rtl/bwg_checker.sv
module bwg_checker #(
  parameter int CNT_W = 16,
  parameter int CAP_W = 16,
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic [CNT_W-1:0] onLen,
  input logic [CNT_W-1:0] offLen,
  input logic [CAP_W-1:0] wordCap,
  input logic             mstValid,
  input logic [LEN_W-1:0] mstLen,
  input logic             slvReady,
  input logic             mstReady,
  input logic             slvValid
);

  AST_TRANSPARENT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (slvValid == mstValid) && (mstReady == slvReady)); // R1

  AST_NEVER_SHUT: assert property (@(posedge clk) disable iff (!rstN)
    enable && offLen == '0 && wordCap == '0 |-> slvValid == mstValid); // R3

  AST_NEVER_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    enable && $past(enable) && onLen == '0 && offLen != '0 &&
    $stable(onLen) && $stable(offLen) |-> !slvValid && !mstReady); // R4

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    slvValid |-> mstValid); // R5

  AST_NO_SPURIOUS_READY: assert property (@(posedge clk) disable iff (!rstN)
    mstReady |-> slvReady); // R5

  AST_OVERSIZE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    enable && wordCap != '0 && slvValid |->
      (CAP_W + 1)'(mstLen) + (CAP_W + 1)'(1) <= (CAP_W + 1)'(wordCap)); // R6

  AST_HANDSHAKE_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (mstValid && mstReady) == (slvValid && slvReady)); // R10

endmodule

bind burst_window_gate bwg_checker #(
  .CNT_W (CNT_W),
  .CAP_W (CAP_W),
  .LEN_W (LEN_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .enable   (enable),
  .onLen    (onLen),
  .offLen   (offLen),
  .wordCap  (wordCap),
  .mstValid (mstValid),
  .mstLen   (mstLen),
  .slvReady (slvReady),
  .mstReady (mstReady),
  .slvValid (slvValid)
);

// File: tb/tb_burst_window_gate.sv
`timescale 1ns/1ps
module tb_burst_window_gate;

  logic        clk = 1'b0;
  logic        rstN;
  logic        enable;
  logic [15:0] onLen, offLen, wordCap;
  logic        mstValid;
  logic [7:0]  mstLen;
  logic        slvReady;
  logic        mstReady, slvValid;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  burst_window_gate dut (
    .clk (clk), .rstN (rstN), .enable (enable),
    .onLen (onLen), .offLen (offLen), .wordCap (wordCap),
    .mstValid (mstValid), .mstLen (mstLen), .slvReady (slvReady),
    .mstReady (mstReady), .slvValid (slvValid)
  );

  // {onLen, offLen, open pattern over 12 cycles after restart, MSB first}
  localparam int NV = 7;
  localparam logic [43:0] VEC [NV] = '{
    {16'd3, 16'd2, 12'b111001110011},
    {16'd1, 16'd1, 12'b101010101010},
    {16'd4, 16'd0, 12'b111111111111},
    {16'd0, 16'd5, 12'b000000000000},
    {16'd2, 16'd3, 12'b110001100011},
    {16'd5, 16'd1, 12'b111110111110},
    {16'd0, 16'd0, 12'b111111111111}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    finish();
  end

  initial begin
    rstN = 0; enable = 0; onLen = 16'd7; offLen = 16'd7; wordCap = 16'd0;
    mstValid = 0; mstLen = 8'd0; slvReady = 0;
    repeat (3) @(posedge clk);
    #2 rstN = 1;

    // R1: transparent while disabled, straight out of reset
    mstValid = 1; slvReady = 0; #2;
    chk("R1 slvValid", slvValid, 1'b1);
    chk("R1 mstReady", mstReady, 1'b0);
    @(posedge clk); #2 mstValid = 0; slvReady = 1; #2;
    chk("R1 slvValid", slvValid, 1'b0);
    chk("R1 mstReady", mstReady, 1'b1);

    // R2 R3 R4 R5 R7 R9: window patterns from the table
    @(posedge clk); #2 enable = 1; mstValid = 1; mstLen = 8'd200; slvReady = 1;
    for (int v = 0; v < NV; v++) begin
      @(posedge clk); #2;
      onLen = VEC[v][43:28]; offLen = VEC[v][27:12];
      @(posedge clk); #4;
      for (int k = 0; k < 12; k++) begin
        if (k > 0) begin @(posedge clk); #4; end
        chk("R2 window slvValid", slvValid, VEC[v][11-k]);
        chk("R5 window mstReady", mstReady, VEC[v][11-k]);
      end
    end

    // R6 R8: budget of 5 words, open 10 cycles, shut 2
    @(posedge clk); #2 onLen = 16'd10; offLen = 16'd2; wordCap = 16'd5; mstValid = 0;
    @(posedge clk); #2 mstValid = 1; mstLen = 8'd2; slvReady = 1; #2;
    chk("R6 3 beats fit 5", slvValid, 1'b1);
    @(posedge clk); #4;
    chk("R6 3 beats exceed 2", slvValid, 1'b0);
    chk("R6 held ready", mstReady, 1'b0);
    @(posedge clk); #2 mstLen = 8'd1; #2;
    chk("R6 2 beats fit 2", slvValid, 1'b1);
    @(posedge clk); #2 mstLen = 8'd0; #2;
    chk("R6 budget empty", slvValid, 1'b0);
    repeat (8) @(posedge clk); #4;
    chk("R5 shut cycle", mstReady, 1'b0);
    @(posedge clk); #4;
    chk("R8 refill at new window", slvValid, 1'b1);
    @(posedge clk); #2 wordCap = 16'd0; mstLen = 8'd255; #2;
    chk("R7 cap zero unlimited", slvValid, 1'b1);

    // R9: rewrite during a shut phase restarts at an open cycle
    @(posedge clk); #2 onLen = 16'd4; offLen = 16'd4; mstLen = 8'd0;
    @(posedge clk); #2 slvReady = 0; #2;
    chk("R10 valid passes", slvValid, 1'b1);
    chk("R10 ready follows", mstReady, 1'b0);
    repeat (5) @(posedge clk); #4;
    chk("R9 shut before rewrite", slvValid, 1'b0);
    onLen = 16'd6;
    @(posedge clk); #4;
    chk("R9 open after rewrite", slvValid, 1'b1);
    repeat (5) @(posedge clk); #4;
    chk("R9 still open", slvValid, 1'b1);
    @(posedge clk); #4;
    chk("R9 shut after 6", slvValid, 1'b0);

    // R1: disabling mid-shut makes the gate transparent at once
    enable = 0; #1;
    chk("R1 disabled passes", slvValid, 1'b1);

    finish();
  end

endmodule